// File: doc/BRIEF.md
# Callee-Saved Frame Push Sequencer

This block stores the extended, callee-saved part of an exception stack frame. An exception entry controller pulses `start` with the frame inputs. The block then picks a stack pointer and computes the frame base 0x28 bytes below it. It issues one word write per accepted bus handshake: an integrity signature first, then registers r4 to r11. When the last write is accepted, it reports the new stack pointer value and which pointer that value belongs to.

When the entry is a tail-chain, the frame goes onto one of the two banked Secure stack pointers. The link value's MODE and SPSEL bits choose which one. Otherwise the frame goes onto the currently active SP. An error response on any write ends the sequence at once. In that case the block raises an error pulse and requests no stack pointer update.

Top module: `callee_frame_pusher`

## Requirements
- R1: While reset is asserted and after it is released, `wr_valid`, `done`, `error` and `sp_upd_valid` are 0 until a `start` is accepted.
- R2: The frame base is the selected stack pointer minus 0x28, using 32-bit wrap-around. The first write goes to the base address and carries the word 0xFEFA125B.
- R3: The next eight writes store r4 to r11 in ascending order at base+0x08, base+0x0C, ... base+0x24. Register r(4+i) is taken from `regs[32*i +: 32]`.
- R4: The word at base+0x04 is never written. A sequence that completes makes exactly nine writes.
- R5: If `tail_chain` is 0, the pointer is `cur_sp` and its code is 0. If `tail_chain` is 1 and both `lr_mode` and `lr_spsel` are 1, the pointer is `sp_proc_s` with code 2. Any other tail-chain case uses `sp_main_s` with code 1.
- R6: A write completes only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R7: The cycle after the last write is accepted, `done` and `sp_upd_valid` pulse for one cycle. At the same time `sp_upd_value` equals the frame base and `sp_upd_sel` gives the code of the pointer that was chosen.
- R8: If `wr_err` is high on an accepted write, the next cycle `error` pulses for one cycle. No further write is issued, and `sp_upd_valid` stays low.
- R9: A `start` that arrives while a sequence is running has no effect. Its pointer, flag and register inputs do not change the addresses or data of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame push; accepted only when idle |
| tail_chain | input | 1 | Entry is a tail-chain |
| lr_mode | input | 1 | Link value MODE bit (1 = thread mode) |
| lr_spsel | input | 1 | Link value SPSEL bit (1 = process stack) |
| cur_sp | input | 32 | Currently active stack pointer |
| sp_main_s | input | 32 | Secure main stack pointer |
| sp_proc_s | input | 32 | Secure process stack pointer |
| regs | input | 256 | r4..r11, r4 in the lowest word |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted this cycle |
| wr_err | input | 1 | Error response with the accepted write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed (pulse) |
| error | output | 1 | Sequence aborted by a bus error (pulse) |
| sp_upd_valid | output | 1 | Stack pointer update request (pulse) |
| sp_upd_sel | output | 2 | 0 current SP, 1 Secure main, 2 Secure process |
| sp_upd_value | output | 32 | New stack pointer value (frame base) |

## Verification
The hardest case to create is a second `start` while a sequence is running, combined with an abort partway through the frame. The bench raises `start` again in the second cycle of a sequence, with a different pointer, flags and register contents. It then confirms that the addresses and data still follow the first request. Error responses are injected at each of the nine write positions in turn, under different stall patterns. After each abort the bench watches that no write follows and no pointer update appears. A frame whose base wraps below address zero is also run.

// File: rtl/callee_frame_pusher.sv
module callee_frame_pusher #(
  parameter int unsigned NREG      = 8,
  parameter logic [31:0] SIGNATURE = 32'hFEFA125B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tail_chain,
  input  logic              lr_mode,
  input  logic              lr_spsel,
  input  logic [31:0]       cur_sp,
  input  logic [31:0]       sp_main_s,
  input  logic [31:0]       sp_proc_s,
  input  logic [32*NREG-1:0] regs,
  output logic              wr_valid,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ready,
  input  logic              wr_err,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              sp_upd_valid,
  output logic [1:0]        sp_upd_sel,
  output logic [31:0]       sp_upd_value
);
  localparam int unsigned IW = $clog2(NREG + 1);
  localparam logic [31:0] FRAME_BYTES = 32'(8 + 4 * NREG);
  localparam logic [IW-1:0] LAST = IW'(NREG);

  logic               busy_q, done_q, err_q;
  logic [IW-1:0]      idx_q;
  logic [31:0]        base_q;
  logic [1:0]         sel_q;
  logic [32*NREG-1:0] regs_q;
  logic [31:0]        pick_sp;
  logic [1:0]         pick_sel;
  logic [IW-1:0]      widx;

  always_comb begin
    if (!tail_chain) begin
      pick_sp  = cur_sp;
      pick_sel = 2'd0;
    end else if (lr_mode && lr_spsel) begin
      pick_sp  = sp_proc_s;
      pick_sel = 2'd2;
    end else begin
      pick_sp  = sp_main_s;
      pick_sel = 2'd1;
    end
  end

  wire accept = busy_q & wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      sel_q  <= '0;
      regs_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        base_q <= pick_sp - FRAME_BYTES;
        sel_q  <= pick_sel;
        regs_q <= regs;
      end else if (accept) begin
        if (wr_err) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end else if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign widx         = idx_q - 1'b1;
  assign wr_valid     = busy_q;
  assign wr_addr      = base_q + ((idx_q == '0) ? 32'd0 : ((32'(idx_q) << 2) + 32'd4));
  assign wr_data      = (idx_q == '0) ? SIGNATURE : regs_q[int'(widx) * 32 +: 32];
  assign busy         = busy_q;
  assign done         = done_q;
  assign error        = err_q;
  assign sp_upd_valid = done_q;
  assign sp_upd_sel   = sel_q;
  assign sp_upd_value = base_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_skip_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr != sp_upd_value + 32'd4);

  assert_signature_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> wr_addr == sp_upd_value && wr_data == SIGNATURE);

  assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !wr_err && wr_addr == sp_upd_value + FRAME_BYTES - 32'd4
    |=> done && sp_upd_valid && !wr_valid);

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !sp_upd_valid && !wr_valid && !done);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(wr_ready && (wr_err || wr_addr == sp_upd_value + FRAME_BYTES - 32'd4))
    |=> busy && $stable(sp_upd_value) && $stable(sp_upd_sel));
endmodule

// File: tb/sim_callee_frame_pusher.sv
module sim_callee_frame_pusher;
  localparam int PERIOD = 10;
  localparam logic [31:0] SIG = 32'hFEFA125B;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic tail_chain = 1'b0, lr_mode = 1'b0, lr_spsel = 1'b0;
  logic [31:0] cur_sp = '0, sp_main_s = '0, sp_proc_s = '0;
  logic [255:0] regs = '0;
  logic wr_valid, wr_ready = 1'b0, wr_err = 1'b0;
  logic [31:0] wr_addr, wr_data, sp_upd_value;
  logic busy, done, error, sp_upd_valid;
  logic [1:0] sp_upd_sel;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  callee_frame_pusher u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tail_chain(tail_chain),
    .lr_mode(lr_mode), .lr_spsel(lr_spsel), .cur_sp(cur_sp),
    .sp_main_s(sp_main_s), .sp_proc_s(sp_proc_s), .regs(regs),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_err(wr_err), .busy(busy), .done(done),
    .error(error), .sp_upd_valid(sp_upd_valid), .sp_upd_sel(sp_upd_sel),
    .sp_upd_value(sp_upd_value));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(req, {28'd0, wr_valid, done, error, sp_upd_valid}, 32'd0);
  endtask

  task automatic run(input bit tc, input bit md, input bit ps, input int stall,
                     input int err_at, input logic [31:0] csp, input int seed);
    logic [31:0] exp_sp, base;
    logic [1:0]  exp_sel;
    logic [31:0] rv [8];
    int w = 0, cyc = 0;
    bit fin = 0, aborted = 0;
    @(negedge clk);
    tail_chain = tc; lr_mode = md; lr_spsel = ps; cur_sp = csp;
    sp_main_s = 32'h3000_0800 ^ (32'(seed) << 4);
    sp_proc_s = 32'h3000_4400 ^ (32'(seed) << 4);
    for (int i = 0; i < 8; i++) begin
      rv[i] = 32'hC0DE_0000 + 32'(seed) * 256 + 32'(i);
      regs[32*i +: 32] = rv[i];
    end
    if (!tc) begin exp_sp = csp; exp_sel = 2'd0; end
    else if (md && ps) begin exp_sp = sp_proc_s; exp_sel = 2'd2; end
    else begin exp_sp = sp_main_s; exp_sel = 2'd1; end
    base = exp_sp - 32'h28;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 200) begin
      chk("R6 valid held", {31'd0, wr_valid}, 32'd1);
      chk("R2/R3/R9 addr", wr_addr, (w == 0) ? base : base + 32'd4 + 32'(w) * 4);
      chk("R2/R3/R9 data", wr_data, (w == 0) ? SIG : rv[w-1]);
      chk("R4 slot skipped", {31'd0, wr_addr == base + 32'd4}, 32'd0);
      start = (cyc == 1);
      if (cyc == 1) begin
        tail_chain = ~tc; lr_mode = ~md; cur_sp = csp ^ 32'h100;
        sp_main_s = sp_main_s ^ 32'h40; sp_proc_s = sp_proc_s ^ 32'h40;
        regs = ~regs;
      end
      wr_ready = ((cyc % (stall + 1)) == stall);
      wr_err = wr_ready && (w == err_at);
      if (wr_ready) begin
        if (wr_err) begin fin = 1; aborted = 1; end
        w++;
        if (w == 9) fin = 1;
      end
      @(negedge clk);
      cyc++;
    end
    if (!fin) begin
      bad++; total++;
      $display("FAIL R6: sequence stuck actual=%0d expected=9 writes", w);
    end
    wr_ready = 1'b0; wr_err = 1'b0; start = 1'b0;
    if (aborted) begin
      chk("R8 error pulse", {31'd0, error}, 32'd1);
      chk("R8 no update", {29'd0, sp_upd_valid, done, wr_valid}, 32'd0);
    end else begin
      chk("R4 write count", 32'(w), 32'd9);
      chk("R7 done", {30'd0, done, sp_upd_valid}, 32'd3);
      chk("R7 no error", {31'd0, error}, 32'd0);
      chk("R5/R7 sel", {30'd0, sp_upd_sel}, {30'd0, exp_sel});
      chk("R2/R7 value", sp_upd_value, base);
      chk("R7 valid dropped", {31'd0, wr_valid}, 32'd0);
    end
    @(negedge clk);
    quiet(aborted ? "R8 after abort" : "R7 single pulse");
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    quiet("R1 after reset");
    chk("R1 busy", {31'd0, busy}, 32'd0);
    for (int tc = 0; tc < 2; tc++)
      for (int md = 0; md < 2; md++)
        for (int ps = 0; ps < 2; ps++)
          for (int st = 0; st < 3; st++)
            run(tc[0], md[0], ps[0], st, 99, 32'h2000_1000 + 32'(st) * 32'h80,
                tc * 12 + md * 6 + ps * 3 + st);
    for (int e = 0; e < 9; e++)
      run(1'b1, e[0], e[1], e % 3, e, 32'h2000_2000, 40 + e);
    run(1'b0, 1'b0, 1'b0, 0, 99, 32'h0000_0010, 60);
    run(1'b1, 1'b1, 1'b1, 1, 99, 32'h0000_0000, 61);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule